// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block is the hardware call stack of a small 8-bit controller core. Subroutine calls and interrupt entries push the current program-counter value. Returns and returns-from-interrupt pop the most recent value, and the block presents that value registered on `ret_addr_o` as the next program counter.

The stack holds a fixed number of slots (eight by default). A call made while every slot is in use still goes through: the newest address overwrites the oldest one, so the slots always hold the most recent calls.

Interrupts are handled differently from calls. A request is latched when it arrives. While the stack is full, the latched request is held and not acknowledged. The acknowledge is released as soon as a pop frees a slot.

Top module: `ret_stack_top`

## Requirements
- R1: The stack holds at most `DEPTH` (default 8) addresses of `ADDR_W` (default 12) bits, and its depth always stays between 0 and `DEPTH`.
- R2: After reset the stack is empty, and `full_o`, `irq_ack_o` and `ret_addr_o` are all 0.
- R3: An `irq_pend_i` pulse that arrives while `full_o` is high is latched. `irq_ack_o` stays low for as long as `full_o` stays high.
- R4: A request held back by a full stack is acknowledged in the cycle right after the edge at which a pop, with no push in the same cycle, leaves the stack with fewer than `DEPTH` entries.
- R5: A push into a full stack stores the new address and discards the oldest one, and `full_o` stays high. A later run of `DEPTH` pops returns the `DEPTH` newest addresses.
- R6: Pops return addresses newest first. `ret_addr_o` takes the popped value after the clock edge of the pop and holds it until the next serviced pop.
- R7: A pop on an empty stack, with no push in the same cycle, changes nothing: `ret_addr_o` keeps its value and the depth stays 0.
- R8: A push and a pop in the same cycle on a non-empty stack perform the pop first and then the push. `ret_addr_o` gets the old top entry, the new address becomes the top, and the depth does not change. On an empty stack only the push takes effect.
- R9: `full_o` is a registered output. It is high exactly when the depth equals `DEPTH`, starting the cycle after the edge that makes it so.
- R10: When the stack is not full, a one-cycle `irq_pend_i` pulse produces a single one-cycle `irq_ack_o` pulse in the cycle after the edge that latches it.
- R11: `call_i` and `irq_entry_i` are equivalent push requests, and `ret_i` and `reti_i` are equivalent pop requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Push request from a subroutine call |
| irq_entry_i | input | 1 | Push request from interrupt entry |
| ret_i | input | 1 | Pop request from a return |
| reti_i | input | 1 | Pop request from a return-from-interrupt |
| push_addr_i | input | ADDR_W | Address to push |
| irq_pend_i | input | 1 | Pending unmasked interrupt request pulse |
| ret_addr_o | output | ADDR_W | Address from the last serviced pop |
| full_o | output | 1 | Depth equals DEPTH (registered) |
| irq_ack_o | output | 1 | Interrupt acknowledge grant |

## Verification
The bench fills the stack and then sends an interrupt request. A design that acknowledges it anyway would let the interrupt entry push corrupt the oldest slot, and a design that drops the request would never acknowledge after the next return. The bench also overflows the stack and then drains it, pops an empty stack, and issues a push and a pop together on empty, partly filled and full stacks. The faults these cases expose are a pointer that wraps on underflow, a depth that goes past eight, and a swap that loses or duplicates an entry. A random mix of all requests then runs against a shift-list model of the stack.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  typedef struct packed {
    logic push;
    logic pop;
  } stk_req_t;

  function automatic int unsigned idx_inc(int unsigned idx, int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned idx_dec(int unsigned idx, int unsigned depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction

endpackage

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);

  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        slot_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = slot_q[i];
    end
  end

endmodule

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_req_t         req_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             pop_ok_o,
  output logic             full_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [IDX_W-1:0] head_q, head_d, top_idx, head_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q;

  assign top_idx  = IDX_W'(idx_dec(int'(head_q), DEPTH));
  assign head_nxt = IDX_W'(idx_inc(int'(head_q), DEPTH));
  assign pop_ok_o = req_i.pop && (cnt_q != '0);
  assign rd_idx_o = top_idx;

  always_comb begin
    head_d   = head_q;
    cnt_d    = cnt_q;
    wr_en_o  = 1'b0;
    wr_idx_o = head_q;
    if (pop_ok_o && req_i.push) begin
      // pop then push: top slot replaced in place
      wr_en_o  = 1'b1;
      wr_idx_o = top_idx;
    end else if (pop_ok_o) begin
      head_d = top_idx;
      cnt_d  = cnt_q - 1'b1;
    end else if (req_i.push) begin
      wr_en_o = 1'b1;
      head_d  = head_nxt;
      // full push overwrites oldest slot, which is the one at head
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == CNT_MAX);
    end
  end

  assign full_o = full_q;

  AST_DEPTH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R1
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && req_i.push && !req_i.pop |=> full_q); // R5
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && req_i.pop && !req_i.push |=> (cnt_q == '0) && $stable(head_q)); // R7
  AST_SWAP_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && req_i.pop && req_i.push |=> $stable(cnt_q) && $stable(head_q)); // R8

endmodule

// File: rtl/ret_stack_irq_gate.sv
module ret_stack_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_pend_i,
  input  logic full_i,
  input  logic pop_ok_i,
  input  logic push_i,
  output logic irq_ack_o
);

  logic flag_q;

  assign irq_ack_o = flag_q && !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= irq_pend_i || (flag_q && !irq_ack_o);
  end

  AST_HOLD_WHILE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && full_i |=> flag_q); // R3
  AST_ACK_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && full_i && pop_ok_i && !push_i |=> irq_ack_o); // R4
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o && !irq_pend_i |=> !irq_ack_o); // R10

endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top
  import ret_stack_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              irq_entry_i,
  input  logic              ret_i,
  input  logic              reti_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              irq_pend_i,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              full_o,
  output logic              irq_ack_o
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stk_req_t          req;
  logic              wr_en, pop_ok;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [ADDR_W-1:0] rd_data, ret_q;

  assign req.push = call_i || irq_entry_i;
  assign req.pop  = ret_i || reti_i;

  ret_stack_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .wr_en_o (wr_en),
    .wr_idx_o(wr_idx),
    .rd_idx_o(rd_idx),
    .pop_ok_o(pop_ok),
    .full_o  (full_o)
  );

  ret_stack_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) mem_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(push_addr_i),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );

  ret_stack_irq_gate gate_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_pend_i(irq_pend_i),
    .full_i    (full_o),
    .pop_ok_i  (pop_ok),
    .push_i    (req.push),
    .irq_ack_o (irq_ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ret_q <= '0;
    else if (pop_ok) ret_q <= rd_data;
  end

  assign ret_addr_o = ret_q;

  AST_RET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_i && !reti_i |=> $stable(ret_addr_o)); // R6

endmodule

// File: tb/ret_stack_tb.sv
module ret_stack_top_tb_top;
  localparam int AW = 12;
  localparam int DP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call, irqe, ret, reti, pend;
  logic [AW-1:0] addr;
  logic [AW-1:0] ret_addr;
  logic          full, ack;

  int checks = 0;
  int fails  = 0;

  logic [AW-1:0] m_s [DP];
  int            m_cnt;
  logic [AW-1:0] m_ret;
  logic          m_flag;

  always #5 clk = ~clk;

  ret_stack_top #(.ADDR_W(AW), .DEPTH(DP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .irq_entry_i(irqe),
    .ret_i(ret), .reti_i(reti), .push_addr_i(addr), .irq_pend_i(pend),
    .ret_addr_o(ret_addr), .full_o(full), .irq_ack_o(ack)
  );

  function automatic logic m_ack();
    return m_flag && (m_cnt != DP);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "ret_addr", int'(ret_addr), int'(m_ret));
    chk(tag, "full", int'(full), int'(m_cnt == DP));
    chk(tag, "irq_ack", int'(ack), int'(m_ack()));
  endtask

  // drive at negedge, update model for the coming edge, check at next negedge
  task automatic step(input logic c, input logic ie, input logic r, input logic ri,
                      input logic p, input logic [AW-1:0] a, input string tag);
    logic ack_now;
    call = c; irqe = ie; ret = r; reti = ri; pend = p; addr = a;
    ack_now = m_ack();
    if ((r || ri) && m_cnt > 0) begin
      m_ret = m_s[m_cnt-1];
      m_cnt--;
    end
    if (c || ie) begin
      if (m_cnt == DP) begin
        for (int i = 0; i < DP - 1; i++) m_s[i] = m_s[i+1];
        m_s[DP-1] = a;
      end else begin
        m_s[m_cnt] = a;
        m_cnt++;
      end
    end
    m_flag = p || (m_flag && !ack_now);
    @(posedge clk);
    @(negedge clk);
    call = 0; irqe = 0; ret = 0; reti = 0; pend = 0;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    call = 0; irqe = 0; ret = 0; reti = 0; pend = 0; addr = '0;
    m_cnt = 0; m_ret = '0; m_flag = 0;
    for (int i = 0; i < DP; i++) m_s[i] = '0;
    repeat (3) @(negedge clk);
    check_all("R2");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R2");

    // R10: request with room available
    step(0, 0, 0, 0, 1, '0, "R10");
    chk("R10", "ack pulse", int'(ack), 1);
    idle("R10");
    chk("R10", "ack single", int'(ack), 0);

    // R1 / R9 / R11: fill with mixed push sources
    for (int i = 0; i < DP; i++) begin
      step(i % 2 == 0, i % 2 == 1, 0, 0, 0, AW'(12'h100 + i), "R9");
      chk("R9", "full timing", int'(full), int'(i == DP - 1));
    end
    // R3: request while full is held
    step(0, 0, 0, 0, 1, '0, "R3");
    idle("R3");
    chk("R3", "no ack while full", int'(ack), 0);
    // R4: pop releases it
    step(0, 0, 1, 0, 0, '0, "R4");
    chk("R4", "ack after pop", int'(ack), 1);
    chk("R6", "pop newest", int'(ret_addr), 12'h107);
    idle("R4");
    // R5: overflow
    step(1, 0, 0, 0, 0, 12'h200, "R5");
    step(0, 1, 0, 0, 0, 12'h201, "R5");
    chk("R5", "full after overflow", int'(full), 1);
    for (int i = 0; i < DP; i++) step(0, 0, i % 2 == 0, i % 2 == 1, 0, '0, "R5");
    chk("R5", "oldest survivor", int'(ret_addr), 12'h101);
    // R7: empty pop
    step(0, 0, 1, 0, 0, '0, "R7");
    chk("R7", "ret held", int'(ret_addr), 12'h101);
    step(0, 0, 0, 1, 0, '0, "R7");
    step(1, 0, 0, 0, 0, 12'h3aa, "R7");
    step(0, 0, 1, 0, 0, '0, "R7");
    chk("R7", "no underflow wrap", int'(ret_addr), 12'h3aa);
    // R8: simultaneous push and pop
    step(1, 0, 1, 0, 0, 12'h3bb, "R8");
    chk("R8", "empty swap keeps ret", int'(ret_addr), 12'h3aa);
    step(1, 0, 0, 0, 0, 12'h3cc, "R8");
    step(0, 1, 0, 1, 0, 12'h3dd, "R8");
    chk("R8", "swap returns old top", int'(ret_addr), 12'h3cc);
    step(0, 0, 1, 0, 0, '0, "R8");
    chk("R8", "swap new top", int'(ret_addr), 12'h3dd);
    step(0, 0, 1, 0, 0, '0, "R8");
    chk("R8", "depth kept", int'(ret_addr), 12'h3bb);

    // R6 / R1: random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom;
      step(r[2:0] == 0, r[5:3] == 0, r[8:6] == 0, r[11:9] == 0, r[15:12] == 0,
           AW'($urandom), "R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule